// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time and Break

This block drives the six gates of a three-phase half-bridge. A prescaled time base counts up from zero to a period value and wraps. Each wrap is an update event. Every channel compares the count with its own compare value to form a reference signal, and it splits that reference into a high-side and a low-side output. A dead-time gap is inserted before every rising edge on either side, so the two switches of one leg are never on together.

Each output has its own enable bit. A commutation sequencer outside the block drives these bits. An output whose bit is cleared is driven to its inactive level (low) and is not released. An active-low break input clears the main output enable and forces all six outputs to their idle level (high). Once the break is gone, the main output enable sets again by itself at the next update event. The prescale, period, compare and dead-time values are static inputs. Compare values pass through a shadow register that loads only at an update event.

Top module: `cpwm_bridge`

## Requirements
- R1: While reset is high, and after it is released until the main output enable first sets, all six outputs are at their idle level 1 and `moe` is 0.
- R2: The counter advances once every `psc_val`+1 clocks, counts 0 to `period_val`, then wraps to 0; the wrap is the update event, so one PWM cycle lasts (`psc_val`+1)×(`period_val`+1) clocks.
- R3: A channel reference is high while the count is below that channel's shadow compare value; the shadow loads from `cmp_val` only at an update event, so a compare change never alters a pulse already in progress. A compare of 0 gives 0 % duty and a compare above `period_val` gives 100 %.
- R4: Both outputs of a channel follow the reference (high side) and its inverse (low side), two clocks late. Every rising edge on either side is delayed by a further D clocks. A reference pulse of D clocks or fewer leaves the output on that side low for the whole pulse.
- R5: D is decoded from the 8-bit `dt_code` as follows. Codes 0xxxxxxx give code[6:0]. Codes 10xxxxxx give (64+code[5:0])×2. Codes 110xxxxx give (32+code[4:0])×8. Codes 111xxxxx give (32+code[4:0])×16. Example: code 164 gives 200.
- R6: While `moe` is 1 and `brk_n` is 1, an output whose enable bit (`en_hi[i]` or `en_lo[i]`) is 0 is driven to 0 at the next clock edge.
- R7: At the first clock edge at which `brk_n` is 0, all six outputs go to 1 and `moe` clears. They stay at 1 while `moe` is 0.
- R8: `moe` sets only at an update event at which `brk_n` is 1.
- R9: While `brk_n` stays 0, `moe` stays 0 even across update events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brk_n | input | 1 | Break request, active low |
| psc_val | input | PSC_W | Prescale divider minus one |
| period_val | input | CNT_W | Last count value of a PWM cycle |
| cmp_val | input | N_CH*CNT_W | Compare values; channel i occupies bits [i*CNT_W +: CNT_W] |
| dt_code | input | 8 | Dead-time code |
| en_hi | input | N_CH | Per-channel high-side output enable |
| en_lo | input | N_CH | Per-channel low-side output enable |
| pwm_hi | output | N_CH | High-side gate outputs |
| pwm_lo | output | N_CH | Low-side gate outputs |
| moe | output | 1 | Main output enable state |

## Verification
The bench drives compare values of 0 and above the period, together with dead times longer than the pulses. A design that mishandled these would either emit a sliver of a pulse or let both sides of a leg rise together. Compare values change in the middle of a pulse: an unshadowed design would cut that pulse short. Break pulses land on update events as well as between them. A design that gave the update event priority would turn `moe` back on while the break is still held. Each range of the dead-time code is timed between the low-side fall and the high-side rise. This exposes a wrong multiplier or offset in the decode.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam int DT_CODE_W = 8;
  localparam int DT_LEN_W  = 10;

  typedef enum logic [1:0] {
    DT_UNIT   = 2'd0,
    DT_DOUBLE = 2'd1,
    DT_OCT    = 2'd2,
    DT_HEX    = 2'd3
  } dt_scale_e;

  typedef logic [DT_LEN_W-1:0] dt_len_t;

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc_val,
  input  logic [CNT_W-1:0] period_val,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);

  logic [PSC_W-1:0] psc_cnt;
  logic             tick;

  assign tick = (psc_cnt >= psc_val);
  assign upd  = tick && (cnt >= period_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_cnt <= '0;
      cnt     <= '0;
    end else begin
      psc_cnt <= tick ? '0 : psc_cnt + 1'b1;
      if (tick) cnt <= upd ? '0 : cnt + 1'b1;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    upd |=> (cnt == '0)); // R2

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R2

endmodule

// File: rtl/cpwm_dt_decode.sv
module cpwm_dt_decode
  import cpwm_pkg::*;
(
  input  logic [DT_CODE_W-1:0] dt_code,
  output dt_len_t              dt_len
);

  dt_scale_e scale;

  always_comb begin
    if (!dt_code[7])      scale = DT_UNIT;
    else if (!dt_code[6]) scale = DT_DOUBLE;
    else if (!dt_code[5]) scale = DT_OCT;
    else                  scale = DT_HEX;
  end

  always_comb begin
    unique case (scale)
      DT_UNIT:   dt_len = dt_len_t'(dt_code[6:0]);
      DT_DOUBLE: dt_len = dt_len_t'({1'b1, dt_code[5:0], 1'b0});
      DT_OCT:    dt_len = dt_len_t'({1'b1, dt_code[4:0], 3'b000});
      default:   dt_len = dt_len_t'({1'b1, dt_code[4:0], 4'b0000});
    endcase
  end

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic             upd,
  input  logic [CNT_W-1:0] cmp_in,
  input  dt_len_t          dt_len,
  output logic             hi_raw,
  output logic             lo_raw
);

  logic [CNT_W-1:0] cmp_sh;
  logic             ref_now;
  logic             ref_d;
  dt_len_t          dt_cnt;
  logic             settled;

  assign ref_now = (cnt < cmp_sh);
  assign settled = (dt_cnt == '0);
  assign hi_raw  = ref_d && settled;
  assign lo_raw  = !ref_d && settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_sh <= '0;
      ref_d  <= 1'b0;
      dt_cnt <= '0;
    end else begin
      if (upd) cmp_sh <= cmp_in;
      ref_d <= ref_now;
      if (ref_now != ref_d)  dt_cnt <= dt_len;
      else if (!settled)     dt_cnt <= dt_cnt - 1'b1;
    end
  end

  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(cmp_sh)); // R3

  AST_DT_BLANK: assert property (@(posedge clk) disable iff (rst)
    ((ref_now != ref_d) && (dt_len != '0)) |=> (!hi_raw && !lo_raw)); // R4

endmodule

// File: rtl/cpwm_bridge.sv
module cpwm_bridge
  import cpwm_pkg::*;
#(
  parameter int   N_CH    = 3,
  parameter int   CNT_W   = 16,
  parameter int   PSC_W   = 16,
  parameter logic IDLE_HI = 1'b1,
  parameter logic IDLE_LO = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  brk_n,
  input  logic [PSC_W-1:0]      psc_val,
  input  logic [CNT_W-1:0]      period_val,
  input  logic [N_CH*CNT_W-1:0] cmp_val,
  input  logic [DT_CODE_W-1:0]  dt_code,
  input  logic [N_CH-1:0]       en_hi,
  input  logic [N_CH-1:0]       en_lo,
  output logic [N_CH-1:0]       pwm_hi,
  output logic [N_CH-1:0]       pwm_lo,
  output logic                  moe
);

  localparam logic [N_CH-1:0] IDLE_HI_V = {N_CH{IDLE_HI}};
  localparam logic [N_CH-1:0] IDLE_LO_V = {N_CH{IDLE_LO}};

  logic [CNT_W-1:0] cnt;
  logic             upd;
  dt_len_t          dt_len;
  logic [N_CH-1:0]  hi_raw;
  logic [N_CH-1:0]  lo_raw;
  logic             force_idle;

  cpwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst(rst), .psc_val(psc_val), .period_val(period_val),
    .cnt(cnt), .upd(upd)
  );

  cpwm_dt_decode u_dt (.dt_code(dt_code), .dt_len(dt_len));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    cpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt), .upd(upd),
      .cmp_in(cmp_val[i*CNT_W +: CNT_W]), .dt_len(dt_len),
      .hi_raw(hi_raw[i]), .lo_raw(lo_raw[i])
    );

    AST_OFF_HI_LOW: assert property (@(posedge clk) disable iff (rst)
      (moe && brk_n && !en_hi[i]) |=> !pwm_hi[i]); // R6
    AST_OFF_LO_LOW: assert property (@(posedge clk) disable iff (rst)
      (moe && brk_n && !en_lo[i]) |=> !pwm_lo[i]); // R6
  end

  assign force_idle = !brk_n || !moe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_hi <= IDLE_HI_V;
      pwm_lo <= IDLE_LO_V;
      moe    <= 1'b0;
    end else begin
      if (force_idle) begin
        pwm_hi <= IDLE_HI_V;
        pwm_lo <= IDLE_LO_V;
      end else begin
        pwm_hi <= en_hi & hi_raw;
        pwm_lo <= en_lo & lo_raw;
      end
      if (!brk_n)   moe <= 1'b0;
      else if (upd) moe <= 1'b1;
    end
  end

  AST_BRK_FORCE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !brk_n |=> (pwm_hi == IDLE_HI_V && pwm_lo == IDLE_LO_V && !moe)); // R7

  AST_MOE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    $rose(moe) |-> $past(upd)); // R8

  AST_BRK_HOLDS_MOE: assert property (@(posedge clk) disable iff (rst)
    (!moe && !brk_n) |=> !moe); // R9

endmodule

// File: tb/cpwm_bridge_test.sv
module cpwm_bridge_test;

  localparam int N = 3;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         brk_n = 1'b1;
  logic [15:0]  psc_val = 16'd0;
  logic [15:0]  period_val = 16'd9;
  logic [15:0]  cmp_b [N];
  logic [N*W-1:0] cmp_val;
  logic [7:0]   dt_code = 8'd0;
  logic [N-1:0] en_hi = '1;
  logic [N-1:0] en_lo = '1;
  logic [N-1:0] pwm_hi;
  logic [N-1:0] pwm_lo;
  logic         moe;

  assign cmp_val = {cmp_b[2], cmp_b[1], cmp_b[0]};

  cpwm_bridge uut (
    .clk(clk), .rst(rst), .brk_n(brk_n), .psc_val(psc_val),
    .period_val(period_val), .cmp_val(cmp_val), .dt_code(dt_code),
    .en_hi(en_hi), .en_lo(en_lo), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .moe(moe)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit chk_on = 0;

  function automatic int dt_ticks(input logic [7:0] c);
    int v = int'(c);
    if (v < 128)      return v;
    else if (v < 192) return (v - 128 + 64) * 2;
    else if (v < 224) return (v - 192 + 32) * 8;
    else              return (v - 224 + 32) * 16;
  endfunction

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model, advanced once per rising edge from pre-edge values
  int    m_psc, m_cnt, m_sh[N], m_run[N];
  bit    m_rprev[N], m_rh[N], m_rl[N], m_moe;
  logic [N-1:0] e_hi, e_lo;
  bit    e_moe;
  string tag_h[N], tag_l[N];

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
    if (rst) begin
      m_psc = 0; m_cnt = 0; m_moe = 0;
      for (int c = 0; c < N; c++) begin
        m_sh[c] = 0; m_run[c] = 100000; m_rprev[c] = 0;
        m_rh[c] = 0; m_rl[c] = 0; tag_h[c] = "R1"; tag_l[c] = "R1";
      end
      e_hi = '1; e_lo = '1; e_moe = 0;
    end else begin
      bit tick, upd, r;
      int d;
      d = dt_ticks(dt_code);
      for (int c = 0; c < N; c++) begin
        if (!brk_n || !m_moe) begin
          e_hi[c] = 1; e_lo[c] = 1; tag_h[c] = "R7"; tag_l[c] = "R7";
        end else begin
          e_hi[c] = en_hi[c] ? m_rh[c] : 1'b0;
          e_lo[c] = en_lo[c] ? m_rl[c] : 1'b0;
          tag_h[c] = en_hi[c] ? "R4" : "R6";
          tag_l[c] = en_lo[c] ? "R4" : "R6";
        end
        r = (m_cnt < m_sh[c]);
        if (r == m_rprev[c]) begin
          if (m_run[c] < 100000) m_run[c]++;
        end else m_run[c] = 1;
        m_rprev[c] = r;
        m_rh[c] = r && (m_run[c] >= d + 1);
        m_rl[c] = !r && (m_run[c] >= d + 1);
      end
      tick = (m_psc >= int'(psc_val));
      upd  = tick && (m_cnt >= int'(period_val));
      m_psc = tick ? 0 : m_psc + 1;
      if (tick) m_cnt = upd ? 0 : m_cnt + 1;
      if (upd) for (int c = 0; c < N; c++) m_sh[c] = int'(cmp_b[c]);
      if (!brk_n) m_moe = 0;
      else if (upd) m_moe = 1;
      e_moe = m_moe;
    end
  end

  // Cycle-by-cycle comparison against the model (R2, R3 via waveform timing)
  always @(negedge clk) begin
    if (chk_on && !done) begin
      for (int c = 0; c < N; c++) begin
        check(tag_h[c], int'(pwm_hi[c]), int'(e_hi[c]));
        check(tag_l[c], int'(pwm_lo[c]), int'(e_lo[c]));
      end
      check(brk_n ? "R8" : "R9", int'(moe), int'(e_moe));
    end
  end

  task automatic do_reset(input int psc, input int per, input int c0,
                          input int c1, input int c2, input logic [7:0] dtc);
    @(negedge clk);
    rst = 1'b1;
    psc_val = 16'(psc); period_val = 16'(per);
    cmp_b[0] = 16'(c0); cmp_b[1] = 16'(c1); cmp_b[2] = 16'(c2);
    dt_code = dtc; en_hi = '1; en_lo = '1; brk_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_rise(input int c, output int n);
    logic prev;
    prev = pwm_hi[c];
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (pwm_hi[c] && !prev) break;
      prev = pwm_hi[c];
    end while (1);
  endtask

  task automatic measure_high(input int c, output int w);
    w = 0;
    while (pwm_hi[c]) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic rand_phase(input int idx);
    int per, brk_left;
    logic [7:0] dtc;
    per = 6 + int'($urandom % 25);
    case ($urandom % 4)
      0: dtc = 8'($urandom % 16);
      1: dtc = 8'h80 | 8'($urandom % 3);
      2: dtc = 8'hC0;
      default: dtc = 8'd0;
    endcase
    if (idx == 0)
      do_reset(int'($urandom % 3), per, 0, per + 1, per / 2, dtc);
    else
      do_reset(int'($urandom % 3), per, int'($urandom % (per + 3)),
               int'($urandom % (per + 3)), int'($urandom % (per + 3)), dtc);
    brk_left = 0;
    for (int k = 0; k < 2500; k++) begin
      @(negedge clk);
      if ($urandom % 60 == 0) begin
        en_hi = 3'($urandom); en_lo = 3'($urandom);
      end
      if (brk_left > 0) begin
        brk_left--;
        if (brk_left == 0) brk_n = 1'b1;
      end else if ($urandom % 200 == 0) begin
        brk_n = 1'b0;
        brk_left = 1 + int'($urandom % 40);
      end
      if ($urandom % 100 == 0)
        cmp_b[$urandom % 3] = 16'($urandom % (per + 3));
    end
    brk_n = 1'b1;
  endtask

  initial begin
    int n, w, d;
    logic [7:0] codes [4];
    void'($urandom(32'd4242));
    cmp_b[0] = 16'd5; cmp_b[1] = 16'd5; cmp_b[2] = 16'd5;
    repeat (3) @(negedge clk);
    chk_on = 1;

    // R1: reset and idle state before the first update event
    do_reset(1, 9, 5, 5, 5, 8'd0);
    @(negedge clk);
    check("R1", int'(pwm_hi), 7);
    check("R1", int'(pwm_lo), 7);
    check("R1", int'(moe), 0);

    // R2 / R3: period and duty with prescale 2, period 10, compare 5, no dead time
    wait_rise(0, n);
    wait_rise(0, n);
    check("R2", n, 20);
    measure_high(0, w);
    check("R3", w, 10);
    wait_rise(0, n);
    cmp_b[0] = 16'd3;               // R3: mid-pulse change must not affect this pulse
    measure_high(0, w);
    check("R3", w, 10);
    wait_rise(0, n);
    measure_high(0, w);
    check("R3", w, 6);

    // R5: each dead-time code range, timed from low-side fall to high-side rise
    codes[0] = 8'd164; codes[1] = 8'h25; codes[2] = 8'hC3; codes[3] = 8'hE1;
    for (int i = 0; i < 4; i++) begin
      do_reset(0, 1499, 750, 750, 750, codes[i]);
      while (!moe) @(negedge clk);
      while (!pwm_lo[0]) @(negedge clk);
      while (pwm_lo[0]) @(negedge clk);
      d = 0;
      while (!pwm_hi[0]) begin
        d++;
        @(negedge clk);
      end
      check("R5", d, dt_ticks(codes[i]));
    end
    check("R5", dt_ticks(8'd164), 200);

    // R4, R6, R7, R8, R9: random phases checked by the cycle model
    for (int p = 0; p < 12; p++) rand_phase(p);

    // R9: break held across several update events
    do_reset(0, 7, 4, 4, 4, 8'd1);
    repeat (20) @(negedge clk);
    brk_n = 1'b0;
    repeat (30) @(negedge clk);
    check("R9", int'(moe), 0);
    check("R7", int'(pwm_hi & pwm_lo), 7);
    brk_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R8", int'(moe), 1);

    done = 1;
    report();
  end

endmodule